// File: doc/BRIEF.md
# Floating-Point Reciprocal Estimate Unit

This block returns a coarse reciprocal of a single IEEE-754 operand. The format is chosen at build time: half, single or double precision. The result carries an 8-bit estimate in the top of its fraction. It is meant as the seed for a refinement loop that lives elsewhere, so no true division is done. The datapath is combinational, and an optional register stage can be placed on the result and the flags.

Around the estimate core, the block handles several special cases:
- NaN propagation and quieting, with a default-NaN option;
- infinities and zeros;
- operands so small that their reciprocal overflows, where the outcome depends on the rounding mode;
- operands so large that their reciprocal is denormal, or flushed to zero when flushing is enabled.

Six exception flags are raised for each operation. They are meant to be ORed into a sticky status word by the caller. Denormal operands are normalized before the estimate is taken, unless flushing is on.

Top module: `frecip_est`

## Requirements
- R1: A NaN operand gives a NaN result. A signaling NaN raises invalid and is returned with its top fraction bit set, all other bits kept. A quiet NaN is returned unchanged with no flag. When dnan_i is 1, every NaN result is the canonical quiet NaN: sign 0, exponent all ones, only the top fraction bit set.
- R2: An infinite operand returns zero with the operand's sign and raises no flag.
- R3: A zero operand returns infinity with the operand's sign and raises divzero.
- R4: For a finite operand with unbiased exponent E and the 8 fraction bits m directly below the leading one, the result exponent is -(E+1). The result fraction holds est(m) in its top 8 bits and zeros below. Here est(m) is the low 8 bits of (floor(2^19/(2a+1))+1)>>1, with a = 256+m.
- R5: When E is below (minimum normal exponent - 2), overflow and inexact are raised. The result is signed infinity or the signed largest normal value, chosen by rmode_i: 00 gives infinity; 01 gives infinity only for a positive sign; 10 gives infinity only for a negative sign; 11 always gives the largest normal value.
- R6: With the effective flush enable set and E at least (bias - 1), the result is signed zero and underflow is raised.
- R7: When the result exponent is one below the minimum normal exponent, the fraction is {1, est} shifted right by one. When it is two below, the fraction is {1, est} shifted right by two. In both cases the exponent field is 0.
- R8: With flushing off, a denormal operand is normalized by a leading-zero count and then follows R4, R5 and R7.
- R9: With the effective flush enable set, a denormal operand is treated as a signed zero: the result is signed infinity, and divzero and indenorm are raised.
- R10: The effective flush enable is flush_half_i in half format and flush_i otherwise. The other input has no effect.
- R11: With OUT_REG set, the result and flags appear one clock after the operand, and reset clears them to zero. With OUT_REG clear, they follow the operand in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output stage |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_i | input | W | Operand (W = 16, 32 or 64 per FMT) |
| rmode_i | input | 2 | Rounding mode: 00 nearest, 01 up, 10 down, 11 toward zero |
| flush_i | input | 1 | Flush enable for single and double format |
| flush_half_i | input | 1 | Flush enable for half format |
| dnan_i | input | 1 | Default-NaN enable |
| res_o | output | W | Reciprocal estimate |
| invalid_o | output | 1 | Signaling NaN operand |
| divzero_o | output | 1 | Zero operand (including a flushed denormal) |
| overflow_o | output | 1 | Reciprocal exceeds the format range |
| underflow_o | output | 1 | Result flushed to zero |
| inexact_o | output | 1 | Raised together with overflow |
| indenorm_o | output | 1 | Denormal operand was flushed |

## Verification
Each fault in the classification, normalization or packing logic shows up in the very operation that exercises it. With the output stage it appears one cycle later as a wrong result word or a wrong flag combination. Errors in the leading-zero count move the result exponent. Errors in the estimate table change only the eight fraction bits below the implied one. Mistakes in the denormal boundaries show up only on the operands whose exponent sits exactly at a threshold. For that reason the directed cases straddle each threshold by one exponent step.

// File: rtl/frecip_pkg.sv
package frecip_pkg;

    typedef enum logic [1:0] {
        RM_NEAREST = 2'b00,
        RM_UP      = 2'b01,
        RM_DOWN    = 2'b10,
        RM_ZERO    = 2'b11
    } rmode_e;

    typedef struct packed {
        logic invalid;
        logic divzero;
        logic overflow;
        logic underflow;
        logic inexact;
        logic indenorm;
    } flags_t;

    // FMT: 0 = half, 1 = single, 2 = double
    function automatic int exp_w(input int fmt);
        case (fmt)
            0:       return 5;
            1:       return 8;
            default: return 11;
        endcase
    endfunction

    function automatic int frac_w(input int fmt);
        case (fmt)
            0:       return 10;
            1:       return 23;
            default: return 52;
        endcase
    endfunction

    // Eight-bit reciprocal seed for mantissa 1.m, m = idx
    function automatic logic [7:0] est_entry(input int idx);
        int a;
        int b;
        int r;
        a = 256 + idx;
        b = 524288 / (2 * a + 1);
        r = (b + 1) / 2;
        return 8'(r);
    endfunction

endpackage

// File: rtl/frecip_lut.sv
module frecip_lut
    import frecip_pkg::*;
(
    input  logic [7:0] idx_i,
    output logic [7:0] est_o
);
    localparam int DEPTH = 256;

    logic [7:0] table_w [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        assign table_w[g] = est_entry(g);
    end

    assign est_o = table_w[idx_i];

endmodule

// File: rtl/frecip_unpack.sv
module frecip_unpack #(
    parameter int EW  = 8,
    parameter int FW  = 23,
    parameter int ESW = EW + 3
) (
    input  logic                  [EW+FW:0] op_i,
    input  logic                            flush_i,
    output logic                            sign_o,
    output logic                            is_nan_o,
    output logic                            is_snan_o,
    output logic                            is_inf_o,
    output logic                            is_zero_o,
    output logic                            flushed_o,
    output logic signed [ESW-1:0]           exp_o,
    output logic                  [7:0]     top8_o
);
    localparam int BIAS = (1 << (EW - 1)) - 1;
    localparam int EMIN = 1 - BIAS;
    localparam int LZW  = $clog2(FW + 1);
    localparam logic signed [ESW-1:0] BIAS_S   = ESW'(BIAS);
    localparam logic signed [ESW-1:0] DNBASE_S = ESW'(EMIN - 1);

    logic [EW-1:0]  ef;
    logic [FW-1:0]  frac;
    logic           ef_zero;
    logic           ef_ones;
    logic           frac_nz;
    logic           denorm;
    logic [LZW-1:0] lz;
    logic [LZW:0]   shamt;
    logic [FW-1:0]  norm;
    logic           found;

    assign ef      = op_i[EW+FW-1:FW];
    assign frac    = op_i[FW-1:0];
    assign ef_zero = (ef == '0);
    assign ef_ones = (ef == '1);
    assign frac_nz = (frac != '0);
    assign denorm  = ef_zero && frac_nz;

    // leading-zero count of the fraction
    always_comb begin
        lz    = '0;
        found = 1'b0;
        for (int i = FW - 1; i >= 0; i--) begin
            if (!found && frac[i]) begin
                found = 1'b1;
                lz    = LZW'(FW - 1 - i);
            end
        end
    end

    assign shamt = {1'b0, lz} + (LZW + 1)'(1);
    assign norm  = frac << shamt;

    always_comb begin
        sign_o    = op_i[EW+FW];
        is_nan_o  = ef_ones && frac_nz;
        is_snan_o = ef_ones && frac_nz && !frac[FW-1];
        is_inf_o  = ef_ones && !frac_nz;
        flushed_o = denorm && flush_i;
        is_zero_o = (ef_zero && !frac_nz) || (denorm && flush_i);
        if (denorm) begin
            exp_o  = DNBASE_S - $signed({{(ESW-LZW){1'b0}}, lz});
            top8_o = norm[FW-1 -: 8];
        end else begin
            exp_o  = $signed({{(ESW-EW){1'b0}}, ef}) - BIAS_S;
            top8_o = frac[FW-1 -: 8];
        end
    end

endmodule

// File: rtl/frecip_pack.sv
module frecip_pack
    import frecip_pkg::*;
#(
    parameter int EW  = 8,
    parameter int FW  = 23,
    parameter int ESW = EW + 3
) (
    input  logic                  [EW+FW:0] op_i,
    input  logic                            sign_i,
    input  logic                            is_nan_i,
    input  logic                            is_snan_i,
    input  logic                            is_inf_i,
    input  logic                            is_zero_i,
    input  logic                            flushed_i,
    input  logic signed [ESW-1:0]           exp_i,
    input  logic                  [7:0]     est_i,
    input  logic                  [1:0]     rmode_i,
    input  logic                            flush_i,
    input  logic                            dnan_i,
    output logic                  [EW+FW:0] res_o,
    output flags_t                          flags_o
);
    localparam int BIAS = (1 << (EW - 1)) - 1;
    localparam int EMIN = 1 - BIAS;
    localparam logic signed [ESW-1:0] OVF_LIM_S = ESW'(EMIN - 2);
    localparam logic signed [ESW-1:0] FTZ_LIM_S = ESW'(-EMIN);
    localparam logic signed [ESW-1:0] SUB1_S    = ESW'(EMIN - 1);
    localparam logic signed [ESW-1:0] SUB2_S    = ESW'(EMIN - 2);
    localparam logic signed [ESW-1:0] BIAS_S    = ESW'(BIAS);

    rmode_e                  rm;
    logic                    to_inf;
    logic signed [ESW-1:0]   res_exp;
    logic signed [ESW-1:0]   biased;
    logic        [FW:0]      ext;
    logic        [FW:0]      ext_sh1;
    logic        [FW:0]      ext_sh2;

    assign rm      = rmode_e'(rmode_i);
    assign res_exp = ~exp_i;               // -(E + 1)
    assign biased  = res_exp + BIAS_S;
    assign ext     = {1'b1, est_i, {(FW-8){1'b0}}};
    assign ext_sh1 = ext >> 1;
    assign ext_sh2 = ext >> 2;

    always_comb begin
        case (rm)
            RM_NEAREST: to_inf = 1'b1;
            RM_UP:      to_inf = !sign_i;
            RM_DOWN:    to_inf = sign_i;
            default:    to_inf = 1'b0;
        endcase
    end

    always_comb begin
        res_o   = '0;
        flags_o = '0;
        if (is_nan_i) begin
            flags_o.invalid = is_snan_i;
            if (dnan_i) begin
                res_o = {1'b0, {EW{1'b1}}, 1'b1, {(FW-1){1'b0}}};
            end else begin
                res_o        = op_i;
                res_o[FW-1]  = 1'b1;
            end
        end else if (is_inf_i) begin
            res_o = {sign_i, {(EW+FW){1'b0}}};
        end else if (is_zero_i) begin
            res_o            = {sign_i, {EW{1'b1}}, {FW{1'b0}}};
            flags_o.divzero  = 1'b1;
            flags_o.indenorm = flushed_i;
        end else if (exp_i < OVF_LIM_S) begin
            flags_o.overflow = 1'b1;
            flags_o.inexact  = 1'b1;
            if (to_inf) begin
                res_o = {sign_i, {EW{1'b1}}, {FW{1'b0}}};
            end else begin
                res_o = {sign_i, {(EW-1){1'b1}}, 1'b0, {FW{1'b1}}};
            end
        end else if (flush_i && (exp_i >= FTZ_LIM_S)) begin
            flags_o.underflow = 1'b1;
            res_o = {sign_i, {(EW+FW){1'b0}}};
        end else if (res_exp == SUB1_S) begin
            res_o = {sign_i, {EW{1'b0}}, ext_sh1[FW-1:0]};
        end else if (res_exp == SUB2_S) begin
            res_o = {sign_i, {EW{1'b0}}, ext_sh2[FW-1:0]};
        end else begin
            res_o = {sign_i, biased[EW-1:0], ext[FW-1:0]};
        end
    end

endmodule

// File: rtl/frecip_est.sv
module frecip_est
    import frecip_pkg::*;
#(
    parameter int FMT     = 1,
    parameter bit OUT_REG = 1'b1,
    localparam int EW     = exp_w(FMT),
    localparam int FW     = frac_w(FMT),
    localparam int W      = 1 + EW + FW
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] op_i,
    input  logic [1:0]   rmode_i,
    input  logic         flush_i,
    input  logic         flush_half_i,
    input  logic         dnan_i,
    output logic [W-1:0] res_o,
    output logic         invalid_o,
    output logic         divzero_o,
    output logic         overflow_o,
    output logic         underflow_o,
    output logic         inexact_o,
    output logic         indenorm_o
);
    localparam int ESW     = EW + 3;
    localparam bit IS_HALF = (FMT == 0);

    typedef struct packed {
        logic [W-1:0] res;
        flags_t       flags;
    } out_t;

    out_t                  out_d;
    out_t                  out_q;
    logic                  flush_eff;
    logic                  sign_w;
    logic                  nan_w;
    logic                  snan_w;
    logic                  inf_w;
    logic                  zero_w;
    logic                  flushed_w;
    logic signed [ESW-1:0] exp_w_s;
    logic        [7:0]     top8_w;
    logic        [7:0]     est_w;
    logic        [W-1:0]   res_w;
    flags_t                flags_w;

    if (IS_HALF) begin : g_half_flush
        assign flush_eff = flush_half_i;
    end else begin : g_wide_flush
        assign flush_eff = flush_i;
    end

    frecip_unpack #(.EW(EW), .FW(FW), .ESW(ESW)) u_unpack (
        .op_i      (op_i),
        .flush_i   (flush_eff),
        .sign_o    (sign_w),
        .is_nan_o  (nan_w),
        .is_snan_o (snan_w),
        .is_inf_o  (inf_w),
        .is_zero_o (zero_w),
        .flushed_o (flushed_w),
        .exp_o     (exp_w_s),
        .top8_o    (top8_w)
    );

    frecip_lut u_lut (
        .idx_i (top8_w),
        .est_o (est_w)
    );

    frecip_pack #(.EW(EW), .FW(FW), .ESW(ESW)) u_pack (
        .op_i      (op_i),
        .sign_i    (sign_w),
        .is_nan_i  (nan_w),
        .is_snan_i (snan_w),
        .is_inf_i  (inf_w),
        .is_zero_i (zero_w),
        .flushed_i (flushed_w),
        .exp_i     (exp_w_s),
        .est_i     (est_w),
        .rmode_i   (rmode_i),
        .flush_i   (flush_eff),
        .dnan_i    (dnan_i),
        .res_o     (res_w),
        .flags_o   (flags_w)
    );

    always_comb begin
        out_d.res   = res_w;
        out_d.flags = flags_w;
    end

    if (OUT_REG) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) out_q <= '0;
            else        out_q <= out_d;
        end
    end else begin : g_comb
        assign out_q = out_d;
    end

    assign res_o       = out_q.res;
    assign invalid_o   = out_q.flags.invalid;
    assign divzero_o   = out_q.flags.divzero;
    assign overflow_o  = out_q.flags.overflow;
    assign underflow_o = out_q.flags.underflow;
    assign inexact_o   = out_q.flags.inexact;
    assign indenorm_o  = out_q.flags.indenorm;

    // ---------------- assertions ----------------
    p_nan_result_r1: assert property (@(posedge clk) disable iff (!rst_n)
        nan_w |-> (out_d.res[W-2 -: EW] == '1) && out_d.res[FW-1]);

    p_inf_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        inf_w |-> (out_d.res[W-2:0] == '0) && (out_d.flags == '0));

    p_zero_divz_r3: assert property (@(posedge clk) disable iff (!rst_n)
        zero_w |-> out_d.flags.divzero && (out_d.res[W-2 -: EW] == '1));

    p_ovf_inexact_r5: assert property (@(posedge clk) disable iff (!rst_n)
        out_d.flags.overflow |-> out_d.flags.inexact && !out_d.flags.underflow);

    p_ftz_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        out_d.flags.underflow |-> (out_d.res[W-2:0] == '0) && flush_eff);

    p_flush_denorm_r9: assert property (@(posedge clk) disable iff (!rst_n)
        out_d.flags.indenorm |-> out_d.flags.divzero && zero_w);

    p_sign_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !nan_w |-> (out_d.res[W-1] == op_i[W-1]));

endmodule

// File: tb/frecip_est_tb.sv
module frecip_est_tb;
    localparam int CLK_PERIOD = 10;

    localparam logic [5:0] F_NONE = 6'b000000;
    localparam logic [5:0] F_INV  = 6'b100000;
    localparam logic [5:0] F_DZ   = 6'b010000;
    localparam logic [5:0] F_OV   = 6'b001000;
    localparam logic [5:0] F_UF   = 6'b000100;
    localparam logic [5:0] F_NX   = 6'b000010;
    localparam logic [5:0] F_ID   = 6'b000001;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] op_s = '0;
    logic [15:0] op_h = '0;
    logic [1:0]  rmode = 2'b00;
    logic        flush = 1'b0;
    logic        flush_h = 1'b0;
    logic        dnan = 1'b0;

    logic [31:0] res_s;
    logic [15:0] res_h;
    logic [5:0]  fl_s;
    logic [5:0]  fl_h;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    frecip_est #(.FMT(1), .OUT_REG(1'b1)) u_dut (
        .clk (clk), .rst_n (rst_n), .op_i (op_s), .rmode_i (rmode),
        .flush_i (flush), .flush_half_i (flush_h), .dnan_i (dnan),
        .res_o (res_s), .invalid_o (fl_s[5]), .divzero_o (fl_s[4]),
        .overflow_o (fl_s[3]), .underflow_o (fl_s[2]), .inexact_o (fl_s[1]),
        .indenorm_o (fl_s[0])
    );

    frecip_est #(.FMT(0), .OUT_REG(1'b0)) u_half (
        .clk (clk), .rst_n (rst_n), .op_i (op_h), .rmode_i (rmode),
        .flush_i (flush), .flush_half_i (flush_h), .dnan_i (dnan),
        .res_o (res_h), .invalid_o (fl_h[5]), .divzero_o (fl_h[4]),
        .overflow_o (fl_h[3]), .underflow_o (fl_h[2]), .inexact_o (fl_h[1]),
        .indenorm_o (fl_h[0])
    );

    function automatic logic [7:0] ref_est(input int m);
        int a;
        int b;
        int r;
        a = 256 + m;
        b = 524288 / (2 * a + 1);
        r = (b + 1) / 2;
        return 8'(r);
    endfunction

    task automatic check(input string req, input logic [31:0] act_r, input logic [5:0] act_f,
                         input logic [31:0] exp_r, input logic [5:0] exp_f);
        checks++;
        if (act_r !== exp_r || act_f !== exp_f) begin
            errors++;
            $display("FAIL %s: result %h flags %b, expected %h flags %b",
                     req, act_r, act_f, exp_r, exp_f);
        end
    endtask

    // single: drive at negedge, registered output visible at next negedge
    task automatic run_s(input logic [31:0] op, input logic [1:0] rm, input logic fl,
                         input logic flh, input logic dn);
        @(negedge clk);
        op_s = op; rmode = rm; flush = fl; flush_h = flh; dnan = dn;
        @(negedge clk);
    endtask

    task automatic run_h(input logic [15:0] op, input logic fl, input logic flh);
        @(negedge clk);
        op_h = op; rmode = 2'b00; flush = fl; flush_h = flh; dnan = 1'b0;
        #1;
    endtask

    task automatic t_reset;
        check("R11 reset", res_s, fl_s, 32'h0, F_NONE);
    endtask

    task automatic t_nan;
        run_s(32'h7F800001, 2'b00, 1'b0, 1'b0, 1'b0);
        check("R1 snan quiet", res_s, fl_s, 32'h7FC00001, F_INV);
        run_s(32'hFFC01234, 2'b00, 1'b0, 1'b0, 1'b0);
        check("R1 qnan pass", res_s, fl_s, 32'hFFC01234, F_NONE);
        run_s(32'hFFA00005, 2'b00, 1'b0, 1'b0, 1'b1);
        check("R1 default nan", res_s, fl_s, 32'h7FC00000, F_INV);
    endtask

    task automatic t_inf_zero;
        run_s(32'hFF800000, 2'b00, 1'b0, 1'b0, 1'b0);
        check("R2 -inf", res_s, fl_s, 32'h80000000, F_NONE);
        run_s(32'h80000000, 2'b00, 1'b0, 1'b0, 1'b0);
        check("R3 -zero", res_s, fl_s, 32'hFF800000, F_DZ);
        run_s(32'h00000000, 2'b11, 1'b0, 1'b0, 1'b0);
        check("R3 +zero", res_s, fl_s, 32'h7F800000, F_DZ);
    endtask

    task automatic t_normal;
        run_s(32'h3F800000, 2'b00, 1'b0, 1'b0, 1'b0);
        check("R4 one", res_s, fl_s, 32'h3F7F8000, F_NONE);
        run_s(32'h3FC00000, 2'b00, 1'b0, 1'b0, 1'b0);
        check("R4 1.5", res_s, fl_s, 32'h3F2A8000, F_NONE);
        for (int i = 0; i < 8; i++) begin
            logic [7:0]  m;
            logic [7:0]  e;
            logic        s;
            logic [31:0] exp_r;
            m = 8'(i * 37 + 3);
            e = 8'(60 + i * 9);
            s = i[0];
            exp_r = {s, 8'(253 - int'(e)), ref_est(int'(m)), 15'h0};
            run_s({s, e, m, 15'h1234}, 2'(i), 1'b0, 1'b0, 1'b0);
            check("R4 pattern", res_s, fl_s, exp_r, F_NONE);
        end
    endtask

    task automatic t_overflow;
        run_s(32'h00000001, 2'b00, 1'b0, 1'b0, 1'b0);
        check("R5 nearest", res_s, fl_s, 32'h7F800000, F_OV | F_NX);
        run_s(32'h00000001, 2'b01, 1'b0, 1'b0, 1'b0);
        check("R5 up pos", res_s, fl_s, 32'h7F800000, F_OV | F_NX);
        run_s(32'h80000001, 2'b01, 1'b0, 1'b0, 1'b0);
        check("R5 up neg", res_s, fl_s, 32'hFF7FFFFF, F_OV | F_NX);
        run_s(32'h00000001, 2'b10, 1'b0, 1'b0, 1'b0);
        check("R5 down pos", res_s, fl_s, 32'h7F7FFFFF, F_OV | F_NX);
        run_s(32'h80100000, 2'b10, 1'b0, 1'b0, 1'b0);
        check("R5 down neg", res_s, fl_s, 32'hFF800000, F_OV | F_NX);
        run_s(32'h80000001, 2'b11, 1'b0, 1'b0, 1'b0);
        check("R5 zero mode", res_s, fl_s, 32'hFF7FFFFF, F_OV | F_NX);
    endtask

    task automatic t_denorm_in;
        run_s(32'h00400000, 2'b00, 1'b0, 1'b0, 1'b0);
        check("R8 denorm top", res_s, fl_s, 32'h7EFF8000, F_NONE);
        run_s(32'h00200000, 2'b00, 1'b0, 1'b0, 1'b0);
        check("R8 denorm edge", res_s, fl_s, 32'h7F7F8000, F_NONE);
        run_s(32'h80400000, 2'b00, 1'b1, 1'b0, 1'b0);
        check("R9 flushed denorm", res_s, fl_s, 32'hFF800000, F_DZ | F_ID);
    endtask

    task automatic t_large;
        run_s(32'h7E800000, 2'b00, 1'b0, 1'b0, 1'b0);
        check("R7 shift one", res_s, fl_s, 32'h007FC000, F_NONE);
        run_s(32'hFF000000, 2'b00, 1'b0, 1'b0, 1'b0);
        check("R7 shift two", res_s, fl_s, 32'h803FE000, F_NONE);
        run_s(32'h7E800000, 2'b00, 1'b1, 1'b0, 1'b0);
        check("R6 flush huge", res_s, fl_s, 32'h00000000, F_UF);
        run_s(32'h7E7FFFFF, 2'b00, 1'b1, 1'b0, 1'b0);
        check("R6 below limit", res_s, fl_s, 32'h00800000, F_NONE);
        run_s(32'h7E800000, 2'b00, 1'b0, 1'b1, 1'b0);
        check("R10 half enable ignored", res_s, fl_s, 32'h007FC000, F_NONE);
    endtask

    task automatic t_half;
        run_h(16'h3C00, 1'b0, 1'b0);
        check("R11 half comb one", {16'h0, res_h}, fl_h, 32'h00003BFC, F_NONE);
        run_h(16'h7400, 1'b1, 1'b0);
        check("R10 half ignores flush_i", {16'h0, res_h}, fl_h, 32'h000003FE, F_NONE);
        run_h(16'h7400, 1'b0, 1'b1);
        check("R10 half flush", {16'h0, res_h}, fl_h, 32'h00000000, F_UF);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_nan();
        t_inf_zero();
        t_normal();
        t_overflow();
        t_denorm_in();
        t_large();
        t_half();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule